// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A fetch stage presents the branch address with a lookup strobe. The block XORs a slice of that address with a global record of recent branch outcomes and uses the result to select one 2-bit saturating counter in a pattern table. One cycle after the strobe, the block presents the taken/not-taken guess. Alongside the guess it presents the table index it used, so the pipeline can carry that index with the branch.

When the branch resolves, the pipeline returns the carried index together with the real outcome. The block moves the selected counter one step toward that outcome. It then shifts the outcome into the history record. Because the pipeline returns the index, training lands on the same entry the lookup read, even if other branches have resolved in the meantime. A combinational flag at resolve time reports whether the counter's opinion disagreed with the real outcome. A bench can use this flag to measure accuracy.

Top module: `gshare_predictor`

## Requirements
- R1: The table index for a lookup is `lookupPc[HIST_BITS+1:2] XOR history`, where history is the value held at the lookup edge; that index appears on `predIndex`.
- R2: `predTaken` is 1 exactly when the selected counter holds 2 or 3, that is, when counter bit 1 is set.
- R3: A resolve with `resolveTaken`=1 raises the counter at `resolveIndex` by one, stopping at 3.
- R4: A resolve with `resolveTaken`=0 lowers the counter at `resolveIndex` by one, stopping at 0.
- R5: Each resolve shifts the history left by one bit and places `resolveTaken` in bit 0.
- R6: `predValid` is 1 for exactly the cycle after a cycle with `lookupValid`=1, and 0 otherwise. `predTaken` and `predIndex` keep their value when there is no lookup.
- R7: Training uses `resolveIndex` as given and never the current history.
- R8: After reset, the history is zero, every counter holds 01 (weakly not-taken), and `predValid`, `predTaken` and `predIndex` are 0.
- R9: `resolveMispredict` is 1 in the same cycle only when `resolveValid`=1 and counter bit 1 at `resolveIndex` differs from `resolveTaken`. It is 0 whenever `resolveValid`=0.
- R10: When a lookup and a resolve occur in the same cycle, the lookup sees the history and counters from before that cycle's update.
- R11: In cycles with `resolveValid`=0, neither the counters nor the history change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request strobe |
| lookupPc | input | PC_WIDTH | Branch address to predict |
| predValid | output | 1 | Prediction present this cycle |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predIndex | output | HIST_BITS | Table index used by the lookup |
| resolveValid | input | 1 | Resolved branch strobe |
| resolveIndex | input | HIST_BITS | Index returned from the lookup |
| resolveTaken | input | 1 | Real branch outcome |
| resolveMispredict | output | 1 | Counter disagreed with the real outcome |

## Verification
A wrong history value changes `predIndex` on the very next lookup, because the index carries the history bits XORed with known address bits. A counter that stepped wrongly or failed to saturate shows up in one of two places. It appears on `resolveMispredict` in the same cycle as the next resolve that names that entry. It also appears on `predTaken` one cycle after the next lookup that selects that entry. The bench therefore keeps its own table and history and compares all three outputs on every cycle. Under random traffic the bench revisits each entry many times, so a corrupted entry is detected within a few hundred cycles.

// File: rtl/gshare_pkg.sv
package gshare_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'b01;
  localparam ctr_t CTR_MAX  = 2'b11;
  localparam ctr_t CTR_MIN  = 2'b00;

  typedef struct packed {
    logic latchPred;
    logic train;
    logic trainUp;
  } strobes_t;
endpackage

// File: rtl/gshare_ctrl.sv
module gshare_ctrl
  import gshare_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     lookupValid,
  input  logic     resolveValid,
  input  logic     resolveTaken,
  output strobes_t strobes,
  output logic     predValid
);

  always_comb begin
    strobes.latchPred = lookupValid;
    strobes.train     = resolveValid;
    strobes.trainUp   = resolveTaken;
  end

  always_ff @(posedge clk) begin
    if (!rstN) predValid <= 1'b0;
    else       predValid <= lookupValid;
  end

  // R6: one valid cycle after each lookup, none otherwise
  assert_pred_follows_R6: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> predValid);
  assert_pred_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !predValid);

endmodule

// File: rtl/gshare_datapath.sv
module gshare_datapath
  import gshare_pkg::*;
#(
  parameter int HIST_BITS  = 8,
  parameter int PC_WIDTH   = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             strobes,
  input  logic [PC_WIDTH-1:0]  lookupPc,
  input  logic                 resolveValid,
  input  logic [HIST_BITS-1:0] resolveIndex,
  input  logic                 resolveTaken,
  output logic                 predTaken,
  output logic [HIST_BITS-1:0] predIndex,
  output logic                 resolveMispredict
);

  localparam int DEPTH   = 1 << HIST_BITS;
  localparam int PC_HIGH = ALIGN_BITS + HIST_BITS;

  logic [HIST_BITS-1:0] history;
  ctr_t                 patternTable [DEPTH];
  logic [HIST_BITS-1:0] lookupIdx;
  ctr_t                 resolvedCtr;
  ctr_t                 nextCtr;
  logic                 unusedPcBits;

  assign unusedPcBits = ^{lookupPc[PC_WIDTH-1:PC_HIGH], lookupPc[ALIGN_BITS-1:0]};
  assign lookupIdx    = lookupPc[PC_HIGH-1:ALIGN_BITS] ^ history;
  assign resolvedCtr  = patternTable[resolveIndex];

  always_comb begin
    nextCtr = resolvedCtr;
    if (strobes.trainUp) begin
      if (resolvedCtr != CTR_MAX) nextCtr = resolvedCtr + 2'd1;
    end else begin
      if (resolvedCtr != CTR_MIN) nextCtr = resolvedCtr - 2'd1;
    end
  end

  assign resolveMispredict = resolveValid & (resolvedCtr[1] ^ resolveTaken);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      history   <= '0;
      predTaken <= 1'b0;
      predIndex <= '0;
      for (int i = 0; i < DEPTH; i++) patternTable[i] <= CTR_INIT;
    end else begin
      if (strobes.latchPred) begin
        predIndex <= lookupIdx;
        predTaken <= patternTable[lookupIdx][1];
      end
      if (strobes.train) begin
        patternTable[resolveIndex] <= nextCtr;
        history <= {history[HIST_BITS-2:0], strobes.trainUp};
      end
    end
  end

  // R5: history shifts with the real outcome entering at bit 0
  assert_hist_shift_R5: assert property (@(posedge clk) disable iff (!rstN)
    resolveValid |=> history == {$past(history[HIST_BITS-2:0]), $past(resolveTaken)});
  // R11: no resolve, history stays put
  assert_hist_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !resolveValid |=> $stable(history));
  // R3: ceiling at 3
  assert_ctr_ceiling_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.train && strobes.trainUp && resolvedCtr == CTR_MAX)
      |=> patternTable[$past(resolveIndex)] == CTR_MAX);
  // R4: floor at 0
  assert_ctr_floor_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.train && !strobes.trainUp && resolvedCtr == CTR_MIN)
      |=> patternTable[$past(resolveIndex)] == CTR_MIN);
  // R1: published index is address slice XOR prior history
  assert_index_hash_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchPred |=> predIndex == ($past(lookupPc[PC_HIGH-1:ALIGN_BITS]) ^ $past(history)));
  // R9: no flag without a resolve
  assert_mispredict_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    !resolveValid |-> !resolveMispredict);

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int HIST_BITS  = 8,
  parameter int PC_WIDTH   = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lookupValid,
  input  logic [PC_WIDTH-1:0]  lookupPc,
  output logic                 predValid,
  output logic                 predTaken,
  output logic [HIST_BITS-1:0] predIndex,
  input  logic                 resolveValid,
  input  logic [HIST_BITS-1:0] resolveIndex,
  input  logic                 resolveTaken,
  output logic                 resolveMispredict
);

  strobes_t strobes;

  gshare_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .lookupValid  (lookupValid),
    .resolveValid (resolveValid),
    .resolveTaken (resolveTaken),
    .strobes      (strobes),
    .predValid    (predValid)
  );

  gshare_datapath #(
    .HIST_BITS  (HIST_BITS),
    .PC_WIDTH   (PC_WIDTH),
    .ALIGN_BITS (ALIGN_BITS)
  ) dp_i (
    .clk               (clk),
    .rstN              (rstN),
    .strobes           (strobes),
    .lookupPc          (lookupPc),
    .resolveValid      (resolveValid),
    .resolveIndex      (resolveIndex),
    .resolveTaken      (resolveTaken),
    .predTaken         (predTaken),
    .predIndex         (predIndex),
    .resolveMispredict (resolveMispredict)
  );

endmodule

// File: tb/gshare_predictor_tb_top.sv
module gshare_predictor_tb_top;
  localparam int H  = 8;
  localparam int PW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lookupValid = 1'b0;
  logic [PW-1:0] lookupPc = '0;
  logic          predValid;
  logic          predTaken;
  logic [H-1:0]  predIndex;
  logic          resolveValid = 1'b0;
  logic [H-1:0]  resolveIndex = '0;
  logic          resolveTaken = 1'b0;
  logic          resolveMispredict;

  int errors = 0;
  int checks = 0;
  int missCount = 0;
  int resolveCount = 0;
  bit finished = 1'b0;

  int           modelCtr [1<<H];
  logic [H-1:0] modelHist;
  logic [H-1:0] expIdx;
  logic         expTaken;

  always #10 clk = ~clk;

  gshare_predictor #(.HIST_BITS(H), .PC_WIDTH(PW), .ALIGN_BITS(2)) dut_i (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupPc(lookupPc),
    .predValid(predValid), .predTaken(predTaken), .predIndex(predIndex),
    .resolveValid(resolveValid), .resolveIndex(resolveIndex),
    .resolveTaken(resolveTaken), .resolveMispredict(resolveMispredict)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [PW-1:0] pcFor(logic [H-1:0] idx, logic [H-1:0] hist);
    return {{(PW-H-2){1'b1}}, idx ^ hist, 2'b11};
  endfunction

  function automatic int stepCtr(int c, bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic doCycle(bit lv, logic [PW-1:0] pc, bit rv, logic [H-1:0] ridx, bit rt,
                         string tag);
    bit expMis;
    @(negedge clk);
    lookupValid = lv; lookupPc = pc;
    resolveValid = rv; resolveIndex = ridx; resolveTaken = rt;
    #1;
    expMis = rv && ((modelCtr[ridx] >= 2) != rt);
    check({"R9 mispredict ", tag}, int'(resolveMispredict), int'(expMis));
    if (rv) resolveCount++;
    if (expMis) missCount++;
    @(posedge clk);
    if (lv) begin
      expIdx   = pc[H+1:2] ^ modelHist;
      expTaken = modelCtr[expIdx] >= 2;
    end
    if (rv) begin
      modelCtr[ridx] = stepCtr(modelCtr[ridx], rt);
      modelHist = {modelHist[H-2:0], rt};
    end
    #1;
    check({"R6 predValid ", tag}, int'(predValid), int'(lv));
    check({"R1 R5 predIndex ", tag}, int'(predIndex), int'(expIdx));
    check({"R2 predTaken ", tag}, int'(predTaken), int'(expTaken));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < (1<<H); i++) modelCtr[i] = 1;
    modelHist = '0;
    expIdx = '0;
    expTaken = 1'b0;

    repeat (3) @(posedge clk);
    #1;
    check("R8 predValid in reset", int'(predValid), 0);
    check("R8 predTaken in reset", int'(predTaken), 0);
    check("R8 predIndex in reset", int'(predIndex), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R8: history is zero, so the index equals the address slice; counter 01 -> not taken
    doCycle(1, 32'h0000_0100, 0, '0, 0, "R8 first lookup");
    check("R8 index equals pc bits", int'(predIndex), 8'h40);
    doCycle(0, '0, 0, '0, 0, "R6 idle hold");

    // R3: train entry 5 upward past the ceiling
    for (int k = 0; k < 4; k++) doCycle(0, '0, 1, 8'd5, 1, "R3 train up");
    check("R3 model ceiling", modelCtr[5], 3);
    doCycle(1, pcFor(8'd5, modelHist), 0, '0, 0, "R3 lookup after saturation");
    check("R3 entry 5 predicts taken", int'(predTaken), 1);

    // R4: train down past the floor
    for (int k = 0; k < 5; k++) doCycle(0, '0, 1, 8'd5, 0, "R4 train down");
    doCycle(1, pcFor(8'd5, modelHist), 0, '0, 0, "R4 lookup after floor");
    check("R4 entry 5 predicts not taken", int'(predTaken), 0);
    doCycle(0, '0, 1, 8'd5, 1, "R4 floor then one step up");
    doCycle(1, pcFor(8'd5, modelHist), 0, '0, 0, "R4 one step from floor");
    check("R4 entry 5 still not taken", int'(predTaken), 0);

    // R10: lookup and resolve of the same entry in one cycle
    for (int k = 0; k < 3; k++)
      doCycle(1, pcFor(8'd9, modelHist), 1, 8'd9, 1, "R10 same-cycle");

    // R7: resolve an index unrelated to the current history
    doCycle(0, '0, 1, ~modelHist, 1, "R7 stale index");
    doCycle(1, pcFor(8'hC3, modelHist), 0, '0, 0, "R7 lookup");

    // R11: lookups only, no state change
    for (int k = 0; k < 8; k++)
      doCycle(1, pcFor(8'(k * 37), modelHist), 0, '0, 0, "R11 no resolve");

    // random traffic
    for (int n = 0; n < 6000; n++) begin
      bit lv, rv, rt;
      logic [PW-1:0] pc;
      logic [H-1:0] ridx;
      lv   = ($urandom % 4) != 0;
      rv   = ($urandom % 3) != 0;
      pc   = $urandom;
      ridx = (($urandom % 2) != 0) ? 8'($urandom % 16) : 8'($urandom);
      rt   = (ridx[0]) ? (($urandom % 8) != 0) : (($urandom % 8) == 0);
      doCycle(lv, pc, rv, ridx, rt, "random");
    end

    $display("info: %0d mispredicts over %0d resolves", missCount, resolveCount);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule